// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It drives a trial code to an external digital-to-analog converter and reads back one comparator bit. That bit is high when the converter's output voltage lies above the unknown input. A one-cycle start request begins a conversion. The block then runs a binary search, settling one result bit per clock from the most significant bit downward, so an n-bit result takes n trial cycles and not the 2^n steps a ramping counter would need.

Each trial raises the bit under test while keeping the bits already decided. The comparator is sampled on the next clock edge: the bit is dropped if the comparator reports "above" and kept otherwise, and the next lower bit is raised for the following trial. When the last bit is settled, the result is copied to the count output and the done flag rises. Both stay put until a new start or a synchronous clear. A start request that arrives while a conversion is running is ignored.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `clear` is high at a rising edge, the next state has `dacCode`, `count` and `done` all zero, and any conversion in progress is abandoned.
- R2: A high `startReq` at an edge where no conversion runs starts one: after that edge `dacCode` has only its most significant bit (bit N-1) set and `done` is low.
- R3: At each trial edge the bit under test is cleared if `cmpAbove` is 1 and kept if it is 0; bits above it are unchanged, and unless it was bit 0 the next lower bit is set.
- R4: Exactly N trial edges follow the start edge; `done` is low after each of the first N-1 and high after the N-th.
- R5: With the comparator reporting whether the code exceeds the input level, the final `count` equals the largest code not above that level, which is all ones when the level is above full scale.
- R6: While idle with `done` high and no start request, `count` and `done` hold their values.
- R7: A start request during a conversion has no effect: the conversion keeps its length and result.
- R8: During a conversion `done` is low and `count` keeps the previous result.
- R9: A start request while `done` is high begins a new conversion and drops `done` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| clear | input | 1 | Synchronous clear, active high |
| startReq | input | 1 | Request to begin a conversion |
| cmpAbove | input | 1 | Comparator: 1 when the DAC output lies above the input |
| dacCode | output | N | Trial code driven to the external DAC |
| count | output | N | Latest completed conversion result |
| done | output | 1 | High once a result is ready, until the next start or clear |

## Verification
The converter is run against input levels at zero, at full scale, above full scale, just below and just above the midpoint, at one, and at alternating-bit patterns. Together these exercise keep and drop decisions at every bit position and show the saturating result. A start pulse placed mid-conversion shows that the search is neither restarted nor lengthened. A clear in mid-search separates abandonment from completion. A start issued while the previous result is still shown proves the restart path from the done state. A behavioural model of the search is compared with all outputs on every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes from the sequencer to the trial datapath.
  typedef struct packed {
    logic clr;   // wipe trial, pointer and result
    logic load;  // begin a search: raise the top bit
    logic step;  // settle the bit under test
    logic last;  // the bit under test is bit 0
  } sarStrobe_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seqState_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       startReq,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

  seqState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (clear) begin
      state  <= SEQ_IDLE;
      bitIdx <= '0;
      doneQ  <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (startReq) begin
            state  <= SEQ_CONV;
            bitIdx <= TOP_IDX;
            doneQ  <= 1'b0;
          end
        end
        SEQ_CONV: begin
          if (bitIdx == '0) begin
            state <= SEQ_IDLE;
            doneQ <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clr  = clear;
    strobe.load = !clear && (state == SEQ_IDLE) && startReq;
    strobe.step = !clear && (state == SEQ_CONV);
    strobe.last = (bitIdx == '0);
  end

  assign busy = (state == SEQ_CONV);
  assign done = doneQ;

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  sarStrobe_t   strobe,
  input  logic         cmpAbove,
  output logic [N-1:0] trialCode,
  output logic [N-1:0] resultCode
);

  logic [N-1:0] trialQ;
  logic [N-1:0] trialNext;
  logic [N-1:0] bitPtr;     // one-hot marker of the bit under test
  logic [N-1:0] resultQ;

  // Per-bit next-state of the trial register.
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N - 1) begin : g_top
      always_comb begin
        if (strobe.load)                   trialNext[i] = 1'b1;
        else if (strobe.step && bitPtr[i]) trialNext[i] = ~cmpAbove;
        else                               trialNext[i] = trialQ[i];
      end
    end else begin : g_low
      always_comb begin
        if (strobe.load)                     trialNext[i] = 1'b0;
        else if (strobe.step && bitPtr[i])   trialNext[i] = ~cmpAbove;
        else if (strobe.step && bitPtr[i+1]) trialNext[i] = 1'b1;
        else                                 trialNext[i] = trialQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clr) begin
      trialQ <= '0;
      bitPtr <= '0;
    end else begin
      trialQ <= trialNext;
      if (strobe.load)      bitPtr <= {1'b1, {(N-1){1'b0}}};
      else if (strobe.step) bitPtr <= bitPtr >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clr)                     resultQ <= '0;
    else if (strobe.step && strobe.last) resultQ <= trialNext;
  end

  assign trialCode  = trialQ;
  assign resultCode = resultQ;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         startReq,
  input  logic         cmpAbove,
  output logic [N-1:0] dacCode,
  output logic [N-1:0] count,
  output logic         done
);

  sarStrobe_t seqStrobe;
  logic       convBusy;

  sar_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .clear    (clear),
    .startReq (startReq),
    .strobe   (seqStrobe),
    .busy     (convBusy),
    .done     (done)
  );

  sar_datapath #(.N(N)) u_dp (
    .clk        (clk),
    .strobe     (seqStrobe),
    .cmpAbove   (cmpAbove),
    .trialCode  (dacCode),
    .resultCode (count)
  );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         clear,
  input logic         startReq,
  input logic         cmpAbove,
  input logic [N-1:0] dacCode,
  input logic [N-1:0] count,
  input logic         done,
  input logic         busy
);

  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  // Trial cycles elapsed in the current search.
  int unsigned trialCnt;
  always_ff @(posedge clk) begin
    if (clear)                 trialCnt <= 0;
    else if (!busy && startReq) trialCnt <= 0;
    else if (busy)             trialCnt <= trialCnt + 1;
  end

  a_r1_clear_zero: assert property (@(posedge clk)
    clear |=> (dacCode == '0 && count == '0 && !done));

  a_r2_first_trial: assert property (@(posedge clk) disable iff (clear)
    (!busy && startReq) |=> (dacCode == MSB_ONLY && !done));

  a_r3_drop_lowers: assert property (@(posedge clk) disable iff (clear)
    (busy && cmpAbove) |=> (dacCode < $past(dacCode)));

  a_r3_keep_raises: assert property (@(posedge clk) disable iff (clear)
    (busy && !cmpAbove) |=> (dacCode > $past(dacCode) || done));

  a_r4_length: assert property (@(posedge clk) disable iff (clear)
    $rose(done) |-> (trialCnt == N));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (clear)
    (!busy && !startReq && done) |=> ($stable(count) && done));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (clear)
    (busy && startReq && trialCnt < N - 1) |=> busy);

  a_r8_busy_not_done: assert property (@(posedge clk) disable iff (clear)
    busy |-> !done);

  a_r8_count_held: assert property (@(posedge clk) disable iff (clear)
    (busy && trialCnt < N - 1) |=> $stable(count));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.N(N)) u_chk (
  .clk      (clk),
  .clear    (clear),
  .startReq (startReq),
  .cmpAbove (cmpAbove),
  .dacCode  (dacCode),
  .count    (count),
  .done     (done),
  .busy     (convBusy)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;

  localparam int N = 8;
  localparam int FULL = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         clear;
  logic         startReq;
  logic         cmpAbove;
  logic [N-1:0] dacCode;
  logic [N-1:0] count;
  logic         done;

  int vin;          // analog level in code units
  int checks = 0;
  int errors = 0;
  bit compareOn = 0;

  always #5 clk = ~clk;

  // Analog model: comparator reports DAC output above the input.
  assign cmpAbove = (int'(dacCode) > vin);

  sar_adc_ctrl #(.N(N)) uut (
    .clk(clk), .clear(clear), .startReq(startReq), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .count(count), .done(done)
  );

  // Behavioural reference of the binary search.
  int  mTrial = 0, mCount = 0, mIdx = 0;
  bit  mBusy = 0, mDone = 0;
  always @(posedge clk) begin
    if (clear) begin
      mTrial = 0; mCount = 0; mIdx = 0; mBusy = 0; mDone = 0;
    end else if (mBusy) begin
      if (mTrial > vin) mTrial = mTrial - (1 << mIdx);
      if (mIdx == 0) begin
        mBusy = 0; mDone = 1; mCount = mTrial;
      end else begin
        mIdx = mIdx - 1;
        mTrial = mTrial + (1 << mIdx);
      end
    end else if (startReq) begin
      mBusy = 1; mIdx = N - 1; mTrial = 1 << (N - 1); mDone = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model (R3, R8 trial and hold behaviour).
  always @(negedge clk) begin
    if (compareOn) begin
      check("R3 dacCode vs model", int'(dacCode), mTrial);
      check("R8 count vs model", int'(count), mCount);
      check("R8 done vs model", int'(done), int'(mDone));
    end
  end

  // Full conversion; optional stray start pulse during the search.
  task automatic convert(input int level, input bit strayStart);
    int expRes;
    expRes = (level > FULL) ? FULL : (level < 0 ? 0 : level);
    vin = level;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2 first trial code", int'(dacCode), 1 << (N - 1));
    check("R2/R9 done low after start", int'(done), 0);
    for (int k = 1; k < N; k++) begin
      startReq = (strayStart && k == 3);
      @(negedge clk);
      check("R4 done low mid-search", int'(done), 0);
    end
    startReq = 1'b0;
    @(negedge clk);
    check("R4 done high after N trials", int'(done), 1);
    check(strayStart ? "R7 result despite stray start" : "R5 final result",
          int'(count), expRes);
  endtask

  initial begin
    clear = 1'b1; startReq = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    check("R1 dacCode after clear", int'(dacCode), 0);
    check("R1 count after clear", int'(count), 0);
    check("R1 done after clear", int'(done), 0);
    clear = 1'b0;
    compareOn = 1;
    @(negedge clk);

    convert(0, 0);
    convert(FULL, 0);
    convert(1 << (N - 1), 0);
    convert((1 << (N - 1)) - 1, 0);
    convert(1, 0);
    convert(FULL + 45, 0);       // above full scale saturates (R5)
    convert(8'hA5, 0);
    convert(8'h5A, 1);           // stray start mid-search (R7)

    // R6: idle hold with the result shown
    vin = 3;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6 count held idle", int'(count), 8'h5A);
      check("R6 done held idle", int'(done), 1);
    end

    // R9: restart straight from the done state
    convert(8'h3C, 0);

    // R1: clear abandons a running search
    vin = 200;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R1 dacCode after mid clear", int'(dacCode), 0);
    check("R1 count after mid clear", int'(count), 0);
    check("R1 done after mid clear", int'(done), 0);
    repeat (N + 2) @(negedge clk);
    check("R1 no completion after clear", int'(done), 0);

    convert(77, 0);

    compareOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule